// File: doc/BRIEF.md
# Clocked 32-bit Integer Arithmetic-Logic Unit

This block computes one integer operation per request on two 32-bit operands. A 4-bit operation code selects signed or unsigned addition, subtraction, multiplication, maximum and minimum, or a bitwise AND, OR, XOR, inversion of operand A, or bit reversal of operand A. The caller raises a single-cycle request strobe while the operands and the code are valid. One clock edge later the block presents the 32-bit result, an overflow flag and a single-cycle completion strobe.

The result and the flag are registered. They keep their value until the next request completes, so a consumer may sample them at any time after the completion strobe. Only one operation is in flight at a time. Reset is asynchronous and active-low.

Top module: `mfalu_top`

## Requirements
- R1: While reset is asserted and right after it, the result, the overflow flag and the completion strobe are all 0.
- R2: The completion strobe is high for exactly the one cycle that follows each cycle in which the request strobe is high, and is low in every other cycle.
- R3: Codes 0 (signed add) and 1 (signed A minus B) return the low 32 bits of the sum or difference. The flag is 1 exactly when the mathematical result lies outside the range -2^31 to 2^31-1.
- R4: Code 2 (signed multiply) returns the low 32 bits of the product. The flag is 1 exactly when the full signed product does not fit in 32 signed bits.
- R5: Codes 3 (signed maximum) and 4 (signed minimum) return the larger or smaller operand under two's-complement ordering, with the flag at 0.
- R6: Codes 5 (unsigned add) and 6 (unsigned A minus B) return the low 32 bits. The flag is the carry out of bit 31 for add, and is 1 for subtract exactly when A is less than B.
- R7: Code 7 (unsigned multiply) returns the low 32 bits of the product. The flag is 1 exactly when any of the upper 32 bits of the 64-bit product is set.
- R8: Codes 8 (unsigned maximum) and 9 (unsigned minimum) return the larger or smaller operand as unsigned numbers, with the flag at 0.
- R9: Codes 10, 11 and 12 return A AND B, A OR B and A XOR B, with the flag at 0.
- R10: Code 13 returns the inverse of A, and code 14 returns A with bit i moved to bit 31-i. Operand B has no effect on either, and the flag is 0.
- R11: Code 15 returns a result of 0 with the flag at 0.
- R12: In cycles without a completion, the result and the flag keep their previous values, whatever the operand and code inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| opnd_a | input | 32 | Operand A |
| opnd_b | input | 32 | Operand B |
| op_sel | input | 4 | Operation code, 0 to 15 |
| in_vld | input | 1 | Single-cycle request strobe |
| res_out | output | 32 | Registered result |
| ovf_out | output | 1 | Registered overflow flag |
| out_vld | output | 1 | Single-cycle completion strobe |

## Verification
The bench aims at the edges of each overflow rule: the most positive value plus one, the most negative value minus one, -1 times -1, products of 2^16 by 2^16 under both signed and unsigned codes, all-ones plus one, and zero minus one. A design that mixed up the signed and unsigned rules, or that took the sign of the wrong operand, would raise or drop the flag on exactly these pairs. Maximum and minimum are fed operands whose sign bits differ, where a signed compare and an unsigned compare disagree. The bench also changes the inputs in idle cycles and runs code 13 and code 14 with varied B values, which exposes a result that drifts when it should hold or that leaks operand B.

// File: rtl/mfalu_pkg.sv
package mfalu_pkg;

  typedef enum logic [3:0] {
    OP_SADD = 4'd0,  OP_SSUB = 4'd1,  OP_SMUL = 4'd2,  OP_SMAX = 4'd3,
    OP_SMIN = 4'd4,  OP_UADD = 4'd5,  OP_USUB = 4'd6,  OP_UMUL = 4'd7,
    OP_UMAX = 4'd8,  OP_UMIN = 4'd9,  OP_AND  = 4'd10, OP_OR   = 4'd11,
    OP_XOR  = 4'd12, OP_INV  = 4'd13, OP_REV  = 4'd14, OP_NONE = 4'd15
  } op_e;

  typedef enum logic [2:0] {
    GRP_ADD, GRP_MUL, GRP_CMP, GRP_LOGIC, GRP_ZERO
  } grp_e;

  typedef enum logic [2:0] {
    LG_AND, LG_OR, LG_XOR, LG_INV, LG_REV
  } lsel_e;

  typedef struct packed {
    grp_e  grp;
    logic  sgn;
    logic  sub;
    logic  pick_max;
    lsel_e lsel;
  } dec_t;

  // Splits an operation code into the controls of the datapath units.
  function automatic dec_t decode_op(op_e op);
    dec_t d;
    d.grp      = GRP_ZERO;
    d.sgn      = 1'b0;
    d.sub      = 1'b0;
    d.pick_max = 1'b0;
    d.lsel     = LG_AND;
    case (op)
      OP_SADD: begin d.grp = GRP_ADD; d.sgn = 1'b1; end
      OP_SSUB: begin d.grp = GRP_ADD; d.sgn = 1'b1; d.sub = 1'b1; end
      OP_SMUL: begin d.grp = GRP_MUL; d.sgn = 1'b1; end
      OP_SMAX: begin d.grp = GRP_CMP; d.sgn = 1'b1; d.pick_max = 1'b1; end
      OP_SMIN: begin d.grp = GRP_CMP; d.sgn = 1'b1; end
      OP_UADD: d.grp = GRP_ADD;
      OP_USUB: begin d.grp = GRP_ADD; d.sub = 1'b1; end
      OP_UMUL: d.grp = GRP_MUL;
      OP_UMAX: begin d.grp = GRP_CMP; d.pick_max = 1'b1; end
      OP_UMIN: d.grp = GRP_CMP;
      OP_AND:  begin d.grp = GRP_LOGIC; d.lsel = LG_AND; end
      OP_OR:   begin d.grp = GRP_LOGIC; d.lsel = LG_OR;  end
      OP_XOR:  begin d.grp = GRP_LOGIC; d.lsel = LG_XOR; end
      OP_INV:  begin d.grp = GRP_LOGIC; d.lsel = LG_INV; end
      OP_REV:  begin d.grp = GRP_LOGIC; d.lsel = LG_REV; end
      default: d.grp = GRP_ZERO;
    endcase
    return d;
  endfunction

  // Signed overflow of an add/subtract, judged from the operand and result signs.
  function automatic logic signed_wrap(logic sa, logic sb, logic sr, logic sub);
    logic same_in;
    same_in = sub ? (sa ^ sb) : ~(sa ^ sb);
    return same_in & (sr ^ sa);
  endfunction

endpackage

// File: rtl/mfalu_addsub.sv
module mfalu_addsub #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] sum,
  output logic         s_ovf,
  output logic         u_ovf
);
  import mfalu_pkg::*;

  logic [W:0] wide;

  // One W+1 bit adder serves both directions; bit W is carry or borrow.
  always_comb begin
    if (sub) wide = {1'b0, a} - {1'b0, b};
    else     wide = {1'b0, a} + {1'b0, b};
  end

  assign sum   = wide[W-1:0];
  assign u_ovf = wide[W];
  assign s_ovf = signed_wrap(a[W-1], b[W-1], wide[W-1], sub);

endmodule

// File: rtl/mfalu_mul.sv
module mfalu_mul #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sgn,
  output logic [W-1:0] prod_lo,
  output logic         ovf
);
  localparam int EW = W + 1;
  localparam int PW = 2 * EW;

  logic signed [EW-1:0] xa;
  logic signed [EW-1:0] xb;
  logic signed [PW-1:0] prod;
  logic [PW-W:0]        hi_s;
  logic [PW-W-1:0]      hi_u;

  // Widening by one bit lets a single signed multiplier cover both modes.
  assign xa   = {sgn & a[W-1], a};
  assign xb   = {sgn & b[W-1], b};
  assign prod = xa * xb;

  assign hi_s    = prod[PW-1:W-1];
  assign hi_u    = prod[PW-1:W];
  assign prod_lo = prod[W-1:0];
  assign ovf     = sgn ? ~((&hi_s) | ~(|hi_s)) : (|hi_u);

endmodule

// File: rtl/mfalu_cmp.sv
module mfalu_cmp #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sgn,
  input  logic         pick_max,
  output logic [W-1:0] pick
);
  logic signed [W:0] xa;
  logic signed [W:0] xb;
  logic              a_lt_b;

  assign xa     = {sgn & a[W-1], a};
  assign xb     = {sgn & b[W-1], b};
  assign a_lt_b = xa < xb;

  always_comb begin
    if (pick_max) pick = a_lt_b ? b : a;
    else          pick = a_lt_b ? a : b;
  end

endmodule

// File: rtl/mfalu_logic.sv
module mfalu_logic #(
  parameter int W = 32
) (
  input  logic [W-1:0]     a,
  input  logic [W-1:0]     b,
  input  mfalu_pkg::lsel_e lsel,
  output logic [W-1:0]     y
);
  import mfalu_pkg::*;

  logic [W-1:0] rev;

  for (genvar i = 0; i < W; i++) begin : g_rev
    assign rev[i] = a[W-1-i];
  end

  always_comb begin
    case (lsel)
      LG_AND:  y = a & b;
      LG_OR:   y = a | b;
      LG_XOR:  y = a ^ b;
      LG_INV:  y = ~a;
      LG_REV:  y = rev;
      default: y = '0;
    endcase
  end

endmodule

// File: rtl/mfalu_top.sv
module mfalu_top #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  input  logic [3:0]   op_sel,
  input  logic         in_vld,
  output logic [W-1:0] res_out,
  output logic         ovf_out,
  output logic         out_vld
);
  import mfalu_pkg::*;

  dec_t         dec;
  logic [W-1:0] add_sum, mul_lo, cmp_pick, lg_y;
  logic         add_sovf, add_uovf, mul_ovf;
  logic [W-1:0] res_nxt;
  logic         ovf_nxt;

  assign dec = decode_op(op_e'(op_sel));

  mfalu_addsub #(.W(W)) u_add (
    .a(opnd_a), .b(opnd_b), .sub(dec.sub),
    .sum(add_sum), .s_ovf(add_sovf), .u_ovf(add_uovf)
  );

  mfalu_mul #(.W(W)) u_mul (
    .a(opnd_a), .b(opnd_b), .sgn(dec.sgn),
    .prod_lo(mul_lo), .ovf(mul_ovf)
  );

  mfalu_cmp #(.W(W)) u_cmp (
    .a(opnd_a), .b(opnd_b), .sgn(dec.sgn), .pick_max(dec.pick_max),
    .pick(cmp_pick)
  );

  mfalu_logic #(.W(W)) u_lg (
    .a(opnd_a), .b(opnd_b), .lsel(dec.lsel), .y(lg_y)
  );

  always_comb begin
    res_nxt = '0;
    ovf_nxt = 1'b0;
    case (dec.grp)
      GRP_ADD: begin
        res_nxt = add_sum;
        ovf_nxt = dec.sgn ? add_sovf : add_uovf;
      end
      GRP_MUL: begin
        res_nxt = mul_lo;
        ovf_nxt = mul_ovf;
      end
      GRP_CMP:   res_nxt = cmp_pick;
      GRP_LOGIC: res_nxt = lg_y;
      default: begin
        res_nxt = '0;
        ovf_nxt = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_out <= '0;
      ovf_out <= 1'b0;
      out_vld <= 1'b0;
    end else begin
      out_vld <= in_vld;
      if (in_vld) begin
        res_out <= res_nxt;
        ovf_out <= ovf_nxt;
      end
    end
  end

endmodule

// File: rtl/mfalu_chk.sv
module mfalu_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] opnd_a,
  input logic [W-1:0] opnd_b,
  input logic [3:0]   op_sel,
  input logic         in_vld,
  input logic [W-1:0] res_out,
  input logic         ovf_out,
  input logic         out_vld
);
  logic flag_free;
  logic carry_w;
  logic borrow_w;

  assign flag_free = (op_sel == 4'd3) || (op_sel == 4'd4) || (op_sel >= 4'd8);
  assign carry_w   = opnd_a > ~opnd_b;
  assign borrow_w  = opnd_a < opnd_b;

  p_vld_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |=> out_vld);
  p_vld_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> !out_vld);
  p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> ($stable(res_out) && $stable(ovf_out)));
  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && flag_free) |=> !ovf_out);
  p_carry_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && op_sel == 4'd5) |=> (ovf_out == $past(carry_w)));
  p_borrow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && op_sel == 4'd6) |=> (ovf_out == $past(borrow_w)));
  p_invert_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && op_sel == 4'd13) |=> ((res_out ^ $past(opnd_a)) == {W{1'b1}}));
  p_reverse_ends_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && op_sel == 4'd14) |=>
      (res_out[0] == $past(opnd_a[W-1]) && res_out[W-1] == $past(opnd_a[0])));
  p_zero_code_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && op_sel == 4'd15) |=> (res_out == '0));

endmodule

bind mfalu_top mfalu_chk #(.W(W)) u_chk (.*);

// File: tb/sim_mfalu_top.sv
`timescale 1ns/1ps
module sim_mfalu_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] opnd_a = '0, opnd_b = '0;
  logic [3:0]  op_sel = '0;
  logic        in_vld = 1'b0;
  logic [31:0] res_out;
  logic        ovf_out, out_vld;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  mfalu_top u0 (.*);

  localparam logic signed [63:0] SMAX = 64'sd2147483647;
  localparam logic signed [63:0] SMIN = -64'sd2147483648;

  // Expected {flag, result} restated from the requirements in 64-bit arithmetic.
  function automatic logic [32:0] model(logic [31:0] a, logic [31:0] b, logic [3:0] op);
    logic signed [63:0] sa, sb, t;
    logic [63:0] ua, ub, u;
    logic [31:0] r;
    logic o;
    sa = {{32{a[31]}}, a}; sb = {{32{b[31]}}, b};
    ua = {32'd0, a};       ub = {32'd0, b};
    r = '0; o = 1'b0;
    case (op)
      4'd0: begin t = sa + sb; r = t[31:0]; o = (t > SMAX) || (t < SMIN); end
      4'd1: begin t = sa - sb; r = t[31:0]; o = (t > SMAX) || (t < SMIN); end
      4'd2: begin t = sa * sb; r = t[31:0]; o = (t > SMAX) || (t < SMIN); end
      4'd3: r = (sa > sb) ? a : b;
      4'd4: r = (sa < sb) ? a : b;
      4'd5: begin u = ua + ub; r = u[31:0]; o = u[32]; end
      4'd6: begin r = a - b; o = (a < b); end
      4'd7: begin u = ua * ub; r = u[31:0]; o = (u[63:32] != 0); end
      4'd8: r = (a > b) ? a : b;
      4'd9: r = (a < b) ? a : b;
      4'd10: r = a & b;
      4'd11: r = a | b;
      4'd12: r = a ^ b;
      4'd13: r = ~a;
      4'd14: for (int i = 0; i < 32; i++) r[31-i] = a[i];
      default: r = '0;
    endcase
    return {o, r};
  endfunction

  function automatic string req_of(logic [3:0] op);
    case (op)
      4'd0, 4'd1:        return "R3";
      4'd2:              return "R4";
      4'd3, 4'd4:        return "R5";
      4'd5, 4'd6:        return "R6";
      4'd7:              return "R7";
      4'd8, 4'd9:        return "R8";
      4'd10, 4'd11, 4'd12: return "R9";
      4'd13, 4'd14:      return "R10";
      default:           return "R11";
    endcase
  endfunction

  task automatic check(string req, string what, logic [32:0] act, logic [32:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Called at a falling edge; returns at a falling edge.
  task automatic do_op(logic [31:0] a, logic [31:0] b, logic [3:0] op, int gap);
    logic [32:0] exp;
    exp = model(a, b, op);
    opnd_a = a; opnd_b = b; op_sel = op; in_vld = 1'b1;
    @(negedge clk);
    in_vld = 1'b0;
    opnd_a = $urandom; opnd_b = $urandom; op_sel = 4'($urandom);
    check("R2", "strobe high", {32'd0, out_vld}, 33'd1);
    check(req_of(op), $sformatf("op %0d result", op), {ovf_out, res_out}, exp);
    for (int g = 0; g < gap; g++) begin
      @(negedge clk);
      opnd_a = $urandom; opnd_b = $urandom; op_sel = 4'($urandom);
      check("R2", "strobe low", {32'd0, out_vld}, 33'd0);
      check("R12", "hold", {ovf_out, res_out}, exp);
    end
  endtask

  initial begin
    logic [31:0] spec [8];
    void'($urandom(32'd20240611));
    spec = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h8000_0000, 32'h7FFF_FFFF,
             32'h0001_0000, 32'hFFFF_0000, 32'h0000_FFFF};
    #12;
    check("R1", "in reset", {ovf_out, res_out}, 33'd0);
    check("R1", "strobe in reset", {32'd0, out_vld}, 33'd0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check("R1", "after reset", {out_vld, res_out}, 33'd0);

    // Directed corners
    do_op(32'h7FFF_FFFF, 32'h1, 4'd0, 1);          // R3 positive wrap
    do_op(32'h8000_0000, 32'h1, 4'd1, 1);          // R3 negative wrap
    do_op(32'hFFFF_FFFF, 32'h1, 4'd0, 1);          // R3 no overflow
    do_op(32'h0001_0000, 32'h0001_0000, 4'd2, 1);  // R4 overflow
    do_op(32'hFFFF_FFFF, 32'hFFFF_FFFF, 4'd2, 1);  // R4 -1*-1
    do_op(32'h8000_0000, 32'h1, 4'd2, 1);          // R4 fits exactly
    do_op(32'hFFFF_8000, 32'h0001_0000, 4'd2, 1);  // R4 -2^31 fits
    do_op(32'h8000_0000, 32'h1, 4'd3, 1);          // R5 signed max
    do_op(32'h8000_0000, 32'h1, 4'd4, 1);          // R5 signed min
    do_op(32'hFFFF_FFFF, 32'h1, 4'd5, 1);          // R6 carry
    do_op(32'h0, 32'h1, 4'd6, 1);                  // R6 borrow
    do_op(32'h5, 32'h5, 4'd6, 1);                  // R6 equal, no borrow
    do_op(32'h0001_0000, 32'h0001_0000, 4'd7, 1);  // R7 overflow
    do_op(32'h0000_FFFF, 32'h0001_0001, 4'd7, 1);  // R7 just fits
    do_op(32'h8000_0000, 32'h1, 4'd8, 1);          // R8 unsigned max
    do_op(32'h8000_0000, 32'h1, 4'd9, 1);          // R8 unsigned min
    do_op(32'hF0F0_1234, 32'h0FF0_FFFF, 4'd10, 1); // R9
    do_op(32'hF0F0_1234, 32'h0FF0_FFFF, 4'd11, 1); // R9
    do_op(32'hF0F0_1234, 32'h0FF0_FFFF, 4'd12, 1); // R9
    do_op(32'h1234_5678, 32'h0, 4'd13, 1);         // R10 invert
    do_op(32'h1234_5678, 32'hFFFF_FFFF, 4'd13, 1); // R10 B ignored
    do_op(32'h0000_0001, 32'h0, 4'd14, 1);         // R10 reverse
    do_op(32'h0000_0001, 32'hDEAD_BEEF, 4'd14, 1); // R10 B ignored
    do_op(32'hFFFF_FFFF, 32'hFFFF_FFFF, 4'd15, 1); // R11
    do_op(32'h1, 32'h2, 4'd0, 4);                  // R12 long hold

    // Constrained random
    for (int k = 0; k < 1500; k++) begin
      logic [31:0] a, b;
      a = ($urandom_range(0, 3) == 0) ? spec[$urandom_range(0, 7)] : $urandom;
      b = ($urandom_range(0, 3) == 0) ? spec[$urandom_range(0, 7)] : $urandom;
      if ($urandom_range(0, 2) == 0) begin a = a >> 16; b = b >> 15; end
      do_op(a, b, 4'($urandom_range(0, 15)), $urandom_range(1, 3));
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual running expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule